// File: doc/BRIEF.md
# Core Power-State Sequencer

This block sequences a processor core through three power states. In the active state every clock runs. In the clock-stopped state the core clock is halted but the bus logic keeps running. In the deep-idle state everything is halted except the frequency synthesizer. A system agent moves the core between the active state and the clock-stopped state with a level request, and the block answers with an acknowledge. From the clock-stopped state, a separate level input sends the core into deep idle. Dropping that input brings the core back to the clock-stopped state.

The clock enables are registered. They follow the state one cycle late, so a gating cell downstream never sees a glitch. Snoop and interrupt requests pass through gates that close in deep idle, so nothing asks the core to act while its clocks are off. Every pin is a plain control level. There is no data stream, so no valid/ready handshake applies.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), the state is active. `state_o` reads 0, `core_clk_en`, `bus_clk_en` and `pll_keep` read 1, and `halt_ack` reads 0.
- R2: In the active state, `halt_req` high moves the block to the clock-stopped state (`state_o` = 1) at the next rising clock edge. `halt_ack` is high whenever `state_o` is 1 or 2.
- R3: In the clock-stopped state, with `halt_req` low and `sleep_in` low, the block returns to the active state (`state_o` = 0) at the next edge.
- R4: In the clock-stopped state, `sleep_in` high moves the block to deep idle (`state_o` = 2) at the next edge. This takes priority over a low `halt_req`.
- R5: `sleep_in` has no effect in the active state. The state stays 0 and the clock enables stay 1.
- R6: The clock enables are registered from the state and change one edge after the state does. The pair (`core_clk_en`, `bus_clk_en`) is (1,1) for the active state, (0,1) for the clock-stopped state and (0,0) for deep idle. `pll_keep` stays 1 in every state.
- R7: `snoop_ack` equals `snoop_req`, and `intr_ack` equals `intr_req` bit by bit, when `state_o` is 0 or 1. Both are all zero when `state_o` is 2.
- R8: In deep idle, `halt_req` is ignored. Only a low `sleep_in` is acted on, and it moves the block to the clock-stopped state at the next edge.
- R9: Asserting `rst_n` in deep idle returns the block at once to the active state with all clock enables at 1.
- R10: `state_o` encodes the active state as 0, the clock-stopped state as 1 and deep idle as 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Request to stop the core clock |
| sleep_in | input | 1 | Deep-idle request level |
| snoop_req | input | 1 | Incoming snoop request |
| intr_req | input | INTR_W | Incoming interrupt requests |
| halt_ack | output | 1 | Core is in the clock-stopped state or deeper |
| core_clk_en | output | 1 | Registered core clock enable |
| bus_clk_en | output | 1 | Registered bus-unit clock enable |
| pll_keep | output | 1 | Keep the frequency synthesizer running |
| snoop_ack | output | 1 | Gated snoop acceptance |
| intr_ack | output | INTR_W | Gated interrupt acceptance |
| state_o | output | 2 | Current state code |

## Verification
The bench asserts `sleep_in` in the active state. A design that decoded sleep from any state would jump to deep idle and drop both enables. It also holds `sleep_in` high together with a low `halt_req` in the clock-stopped state. A design with the wrong priority would fall back to the active state instead of going to deep idle. In deep idle the bench toggles `halt_req` and raises snoops and interrupts. A leaky design would change state or pass an acknowledge through. Enables are sampled both in the cycle of a state change and one cycle after it, so combinational enables or enables two cycles late are both caught. A reset applied from deep idle must restore all enables at once.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_HALTED = 2'd1,
    PS_DEEP   = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic core_en;
    logic bus_en;
  } clk_en_t;
endpackage

// File: rtl/pwr_seq_next.sv
module pwr_seq_next
  import pwr_seq_pkg::*;
(
  input  pwr_state_e cur,
  input  logic       halt_req,
  input  logic       sleep_in,
  output pwr_state_e nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      PS_ACTIVE: if (halt_req) nxt = PS_HALTED;
      PS_HALTED: begin
        if (sleep_in)       nxt = PS_DEEP;
        else if (!halt_req) nxt = PS_ACTIVE;
      end
      PS_DEEP:   if (!sleep_in) nxt = PS_HALTED;
      default:   nxt = PS_ACTIVE;
    endcase
  end
endmodule

// File: rtl/pwr_seq_clk.sv
module pwr_seq_clk
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e cur,
  output clk_en_t    en,
  output logic       pll_keep
);
  clk_en_t en_d;

  always_comb begin
    unique case (cur)
      PS_ACTIVE: en_d = '{core_en: 1'b1, bus_en: 1'b1};
      PS_HALTED: en_d = '{core_en: 1'b0, bus_en: 1'b1};
      default:   en_d = '{core_en: 1'b0, bus_en: 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '{core_en: 1'b1, bus_en: 1'b1};
      pll_keep <= 1'b1;
    end else begin
      en       <= en_d;
      pll_keep <= 1'b1;
    end
  end

  // R6
  core_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cur) != PS_ACTIVE && cur == PS_ACTIVE |=> en.core_en);
  // R6
  deep_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur == PS_DEEP |=> !en.bus_en);
endmodule

// File: rtl/pwr_seq_gate.sv
module pwr_seq_gate
  import pwr_seq_pkg::*;
#(
  parameter int INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwr_state_e        cur,
  input  logic              snoop_req,
  input  logic [INTR_W-1:0] intr_req,
  output logic              snoop_ack,
  output logic [INTR_W-1:0] intr_ack
);
  logic open_gate;
  assign open_gate = (cur != PS_DEEP);

  assign snoop_ack = snoop_req & open_gate;
  for (genvar i = 0; i < INTR_W; i++) begin : g_intr
    assign intr_ack[i] = intr_req[i] & open_gate;
  end

  // R7
  deep_no_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur == PS_DEEP |-> !snoop_ack && intr_ack == '0);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              sleep_in,
  input  logic              snoop_req,
  input  logic [INTR_W-1:0] intr_req,
  output logic              halt_ack,
  output logic              core_clk_en,
  output logic              bus_clk_en,
  output logic              pll_keep,
  output logic              snoop_ack,
  output logic [INTR_W-1:0] intr_ack,
  output logic [1:0]        state_o
);
  pwr_state_e state_q, state_d;
  clk_en_t    en;

  pwr_seq_next u_next (
    .cur      (state_q),
    .halt_req (halt_req),
    .sleep_in (sleep_in),
    .nxt      (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_ACTIVE;
    else        state_q <= state_d;
  end

  pwr_seq_clk u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (state_q),
    .en       (en),
    .pll_keep (pll_keep)
  );

  pwr_seq_gate #(.INTR_W(INTR_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur       (state_q),
    .snoop_req (snoop_req),
    .intr_req  (intr_req),
    .snoop_ack (snoop_ack),
    .intr_ack  (intr_ack)
  );

  assign core_clk_en = en.core_en;
  assign bus_clk_en  = en.bus_en;
  assign halt_ack    = (state_q != PS_ACTIVE);
  assign state_o     = state_q;

  // R4
  halt_to_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PS_HALTED && sleep_in |=> state_q == PS_DEEP);
  // R5
  active_no_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PS_ACTIVE |=> state_q != PS_DEEP);
  // R8
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PS_DEEP && sleep_in |=> state_q == PS_DEEP);
  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);
endmodule

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;
  localparam int W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_req = 0, sleep_in = 0, snoop_req = 0;
  logic [W-1:0] intr_req = '0;
  logic halt_ack, core_clk_en, bus_clk_en, pll_keep, snoop_ack;
  logic [W-1:0] intr_ack;
  logic [1:0] state_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwr_seq_top #(.INTR_W(W)) i_pwr_seq_top (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_in(sleep_in),
    .snoop_req(snoop_req), .intr_req(intr_req), .halt_ack(halt_ack),
    .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .pll_keep(pll_keep),
    .snoop_ack(snoop_ack), .intr_ack(intr_ack), .state_o(state_o));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // {state, core, bus, pll, ack}
  function automatic logic [7:0] snap();
    return {2'b0, state_o, core_clk_en, bus_clk_en, pll_keep, halt_ack};
  endfunction

  task automatic t_reset();
    step(); rst_n = 0; #1;
    chk("R1 reset", snap(), {2'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0});
    step(); rst_n = 1; step();
  endtask

  task automatic t_sleep_in_active();
    sleep_in = 1; step();
    chk("R5 state", snap(), {2'b0, 2'd0, 4'b1110});
    step();
    chk("R5 enables", snap(), {2'b0, 2'd0, 4'b1110});
    sleep_in = 0;
  endtask

  task automatic t_halt_and_back();
    halt_req = 1; step();
    chk("R2 state+ack", {state_o, halt_ack}, {3'b011});
    chk("R6 enables lag", {core_clk_en, bus_clk_en}, 2'b11);
    step();
    chk("R6 halted enables", {core_clk_en, bus_clk_en, pll_keep}, 3'b011);
    snoop_req = 1; intr_req = 4'b1010; #1;
    chk("R7 halted pass", {snoop_ack, intr_ack}, 5'b11010);
    snoop_req = 0; intr_req = '0;
    halt_req = 0; step();
    chk("R3 back", {state_o, halt_ack}, 3'b000);
    step();
    chk("R6 active enables", {core_clk_en, bus_clk_en}, 2'b11);
  endtask

  task automatic t_deep();
    halt_req = 1; step(); step();
    halt_req = 0; sleep_in = 1; step();
    chk("R4 priority", state_o, 2'd2);
    chk("R6 deep lag", {core_clk_en, bus_clk_en}, 2'b01);
    step();
    chk("R6 deep enables", {core_clk_en, bus_clk_en, pll_keep}, 3'b001);
    halt_req = 1; step(); halt_req = 0; step();
    chk("R8 ignore halt", state_o, 2'd2);
    snoop_req = 1; intr_req = 4'b1111; #1;
    chk("R7 deep gated", {snoop_ack, intr_ack}, 5'b0);
    snoop_req = 0; intr_req = '0;
    halt_req = 1; sleep_in = 0; step();
    chk("R8 wake", state_o, 2'd1);
    step();
    chk("R8 bus restart", {core_clk_en, bus_clk_en}, 2'b01);
    halt_req = 0; step();
    chk("R10 active code", state_o, 2'd0);
  endtask

  task automatic t_reset_from_deep();
    halt_req = 1; step(); sleep_in = 1; step(); step();
    chk("R9 in deep", state_o, 2'd2);
    halt_req = 0; sleep_in = 0; rst_n = 0; #1;
    chk("R9 reset", snap(), {2'b0, 2'd0, 4'b1110});
    step(); rst_n = 1; step();
  endtask

  initial begin
    #(4 * 10000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sleep_in_active();
    t_halt_and_back();
    t_deep();
    t_reset_from_deep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule